// File: doc/BRIEF.md
# I2C Master Byte Transmit Engine

This block is the transmit and control core of an I2C bus master. Software-facing controls are a start request bit, a stop request bit, a byte-wide data register and a transmit-enable bit that is set whenever the data register is written. The engine puts a START condition on the bus and shifts each queued byte out on SDA while it drives SCL. On the ninth clock of every byte it releases SDA and records the acknowledge bit returned by the slave. A STOP request ends the transfer and frees the bus.

The data register and the shift register form a two-stage pipeline. When a byte moves from the data register into the shifter, the transmit-enable bit clears itself and a one-cycle interrupt pulse is raised, so the next byte can be loaded while the current one is still on the wire. A byte requested while another is in flight waits until that byte, including its acknowledge clock, has finished. Address bytes and data bytes go through the same path. Both bus lines are modelled as open-drain: an output-enable of 1 pulls the line low, and 0 releases it. SCL timing comes from the system clock through a divider whose half-period is set at an input.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), and busy, irq, nak, start_pend, stop_pend and tx_pend are all 0.
- R2: A pulse on start_set makes start_pend read 1. From an idle bus the engine then pulls SDA low while SCL is released (START). In the same cycle start_pend returns to 0 and busy becomes 1.
- R3: A write on data_wr sets tx_pend. If a byte is being shifted at that moment, the new byte starts only after the current byte's ninth clock. Bytes appear on the bus in the order they were written.
- R4: When a byte is copied into the shifter, tx_pend goes to 0 and irq is high for exactly one cycle, both at the same clock edge.
- R5: Bits leave MSB first. SDA changes only while SCL is low, except at START (SDA falling) and STOP (SDA rising) with SCL high.
- R6: Each byte produces exactly 9 SCL high pulses. SDA is released for the whole ninth pulse.
- R7: At the end of the ninth SCL high phase SDA is sampled into nak (1 = slave left SDA high, 0 = slave pulled it low). nak holds this value until the next byte's ninth clock.
- R8: Every SCL high phase of a data bit lasts exactly half_cfg+1 system clock cycles.
- R9: A pulse on stop_set, with the bus held between bytes, gives SDA low then SCL released, then SDA released while SCL is high (STOP). In that same cycle busy and stop_pend return to 0.
- R10: A start_set pulse while the bus is busy and between bytes releases SDA, releases SCL, and then issues a new START without a STOP in between. busy stays 1 throughout.
- R11: While the bus is not busy, SCL is never pulled low. A transmit request written on an idle bus stays pending and produces no clocks until a START has been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cfg | input | DIV_W | SCL half-period minus one, in system clocks |
| start_set | input | 1 | Single-cycle request to issue a START (or repeated START) |
| stop_set | input | 1 | Single-cycle request to issue a STOP |
| data_wr | input | 1 | Single-cycle write of data_in into the data register; also sets tx_pend |
| data_in | input | DATA_W | Byte to transmit (address with direction bit, or data) |
| sda_in | input | 1 | Sampled level of the SDA line |
| start_pend | output | 1 | START request still outstanding |
| stop_pend | output | 1 | STOP request still outstanding |
| tx_pend | output | 1 | Transmit-enable: a byte waits in the data register |
| busy | output | 1 | Bus owned between START and STOP |
| nak | output | 1 | Acknowledge bit captured on the last ninth clock |
| irq | output | 1 | One-cycle pulse when the data register becomes free |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with DATA_W = 8 and DIV_W = 8 and drives half_cfg at 3, so every SCL phase lasts four system clocks. A full byte then fits in about 72 cycles, and a single run can cover the pending-before-START case, a table of bytes with both acknowledge polarities, back-to-back queuing, a repeated START and a STOP. Because the phase is short but wider than one cycle, the high-phase width check of R8 can tell the divider reload value from an off-by-one reload.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_STA_SDA,
    SQ_HOLD,
    SQ_BIT_LO,
    SQ_BIT_HI,
    SQ_RS_REL,
    SQ_RS_HI,
    SQ_STO_LO,
    SQ_STO_HI
  } seq_state_e;

endpackage

// File: rtl/i2c_tx_tick.sv
module i2c_tx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? half_cfg : cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_tx_regs.sv
module i2c_tx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_set,
  input  logic              stop_set,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              clr_start,
  input  logic              clr_stop,
  input  logic              load_tx,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              tx_pend,
  output logic [DATA_W-1:0] tx_data
);

  logic              start_d;
  logic              stop_d;
  logic              tx_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  // A new software request wins over a same-cycle clear from the sequencer.
  always_comb begin
    start_d = start_set ? 1'b1 : (clr_start ? 1'b0 : start_pend);
    stop_d  = stop_set  ? 1'b1 : (clr_stop  ? 1'b0 : stop_pend);
    tx_d    = data_wr   ? 1'b1 : (load_tx   ? 1'b0 : tx_pend);
    data_en = data_wr;
    data_d  = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      tx_pend    <= 1'b0;
    end else begin
      start_pend <= start_d;
      stop_pend  <= stop_d;
      tx_pend    <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_data <= '0;
    else if (data_en) tx_data <= data_d;
  end

endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
  import i2c_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_pend,
  input  logic              stop_pend,
  input  logic              tx_pend,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sda_in,
  output logic              load_tx,
  output logic              clr_start,
  output logic              clr_stop,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              nak
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bit_q,   bit_d;
  logic [DATA_W-1:0] sh_q,    sh_d;
  logic              scl_d;
  logic              sda_d;
  logic              busy_d;
  logic              nak_d;
  logic              irq_d;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    scl_d     = scl_oe;
    sda_d     = sda_oe;
    busy_d    = busy;
    nak_d     = nak;
    irq_d     = 1'b0;
    load_tx   = 1'b0;
    clr_start = 1'b0;
    clr_stop  = 1'b0;
    if (tick) begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_pend) begin
            sda_d     = 1'b1;
            busy_d    = 1'b1;
            clr_start = 1'b1;
            state_d   = SQ_STA_SDA;
          end else if (stop_pend) begin
            clr_stop = 1'b1;
          end
        end
        SQ_STA_SDA: begin
          scl_d   = 1'b1;
          state_d = SQ_HOLD;
        end
        SQ_HOLD: begin
          if (tx_pend) begin
            load_tx = 1'b1;
            irq_d   = 1'b1;
            sh_d    = tx_data;
            bit_d   = '0;
            sda_d   = ~tx_data[DATA_W-1];
            state_d = SQ_BIT_LO;
          end else if (start_pend) begin
            sda_d   = 1'b0;
            state_d = SQ_RS_REL;
          end else if (stop_pend) begin
            sda_d   = 1'b1;
            state_d = SQ_STO_LO;
          end
        end
        SQ_BIT_LO: begin
          scl_d   = 1'b0;
          state_d = SQ_BIT_HI;
        end
        SQ_BIT_HI: begin
          scl_d = 1'b1;
          if (bit_q == ACK_SLOT) begin
            nak_d   = sda_in;
            state_d = SQ_HOLD;
          end else begin
            bit_d   = bit_q + CNT_W'(1);
            state_d = SQ_BIT_LO;
            if (bit_q == LAST_DATA) begin
              sda_d = 1'b0;
            end else begin
              sda_d = ~sh_q[DATA_W-2];
              sh_d  = {sh_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        SQ_RS_REL: begin
          scl_d   = 1'b0;
          state_d = SQ_RS_HI;
        end
        SQ_RS_HI: begin
          sda_d     = 1'b1;
          clr_start = 1'b1;
          state_d   = SQ_STA_SDA;
        end
        SQ_STO_LO: begin
          scl_d   = 1'b0;
          state_d = SQ_STO_HI;
        end
        SQ_STO_HI: begin
          sda_d    = 1'b0;
          busy_d   = 1'b0;
          clr_stop = 1'b1;
          state_d  = SQ_IDLE;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      nak     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      scl_oe  <= scl_d;
      sda_oe  <= sda_d;
      busy    <= busy_d;
      nak     <= nak_d;
      irq     <= irq_d;
    end
  end

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_cfg,
  input  logic              start_set,
  input  logic              stop_set,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              sda_in,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              tx_pend,
  output logic              busy,
  output logic              nak,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  logic                   tick;
  logic                   load_tx;
  logic                   clr_start;
  logic                   clr_stop;
  logic [DATA_W-1:0]      tx_data;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  i2c_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .half_cfg (half_cfg),
    .tick     (tick)
  );

  i2c_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_set  (start_set),
    .stop_set   (stop_set),
    .data_wr    (data_wr),
    .data_in    (data_in),
    .clr_start  (clr_start),
    .clr_stop   (clr_stop),
    .load_tx    (load_tx),
    .start_pend (start_pend),
    .stop_pend  (stop_pend),
    .tx_pend    (tx_pend),
    .tx_data    (tx_data)
  );

  i2c_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick       (tick),
    .start_pend (start_pend),
    .stop_pend  (stop_pend),
    .tx_pend    (tx_pend),
    .tx_data    (tx_data),
    .sda_in     (sda_in),
    .load_tx    (load_tx),
    .clr_start  (clr_start),
    .clr_stop   (clr_stop),
    .busy       (busy),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .irq        (irq),
    .nak        (nak)
  );

endmodule

// File: rtl/i2c_tx_checker.sv
module i2c_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic data_wr,
  input logic start_pend,
  input logic stop_pend,
  input logic tx_pend,
  input logic busy,
  input logic irq,
  input logic scl_oe,
  input logic sda_oe
);

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_frees_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !data_wr) |-> !tx_pend);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend) |-> busy);

  p_busy_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_oe && !scl_oe));

  p_sda_fall_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> busy);

  p_sda_rise_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> !busy);

  p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> !busy);

  p_idle_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_oe);

endmodule

bind i2c_tx_master i2c_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_wr    (data_wr),
  .start_pend (start_pend),
  .stop_pend  (stop_pend),
  .tx_pend    (tx_pend),
  .busy       (busy),
  .irq        (irq),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe)
);

// File: tb/i2c_tx_master_tb_top.sv
module i2c_tx_master_tb_top;

  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int HALF   = 3;
  localparam int NVEC   = 5;
  // {slave acknowledges, byte}
  localparam logic [8:0] VEC [NVEC] = '{9'h181, 9'h000, 9'h1FF, 9'h05A, 9'h1C6};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  half_cfg = DIV_W'(HALF);
  logic              start_set = 1'b0;
  logic              stop_set = 1'b0;
  logic              data_wr = 1'b0;
  logic [DATA_W-1:0] data_in = '0;
  logic              sda_in;
  logic              start_pend, stop_pend, tx_pend, busy, nak, irq, scl_oe, sda_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bus and slave model
  logic       scl_line, sda_line, pull, ack_en;
  logic       scl_prev, sda_prev;
  int         bitn, rises, per_byte, starts, stops, bytes_done, hi_cnt, last_hi;
  logic [7:0] shin;
  logic [7:0] log_q [32];

  assign scl_line = ~scl_oe;
  assign sda_line = ~sda_oe & ~pull;
  assign sda_in   = sda_line;

  always #5 clk = ~clk;

  i2c_tx_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_cfg(half_cfg), .start_set(start_set),
    .stop_set(stop_set), .data_wr(data_wr), .data_in(data_in), .sda_in(sda_in),
    .start_pend(start_pend), .stop_pend(stop_pend), .tx_pend(tx_pend),
    .busy(busy), .nak(nak), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1; sda_prev <= 1'b1; pull <= 1'b0;
      bitn <= 0; rises <= 0; per_byte <= 0; starts <= 0; stops <= 0;
      bytes_done <= 0; hi_cnt <= 0; last_hi <= 0; shin <= '0;
    end else begin
      scl_prev <= scl_line;
      sda_prev <= sda_line;
      if (!scl_line) pull <= (bitn == 8) ? ack_en : 1'b0;
      if (scl_line && scl_prev && sda_prev && !sda_line) begin
        starts <= starts + 1; bitn <= 0; rises <= 0;
      end else if (scl_line && scl_prev && !sda_prev && sda_line) begin
        stops <= stops + 1; bitn <= 0;
      end else if (scl_line && !scl_prev) begin
        hi_cnt <= 1;
        if (bitn < 8) begin
          shin <= {shin[6:0], sda_line};
          bitn <= bitn + 1;
          rises <= rises + 1;
        end else begin
          log_q[bytes_done[4:0]] <= shin;
          per_byte <= rises + 1;
          bytes_done <= bytes_done + 1;
          rises <= 0;
          bitn <= 0;
        end
      end else if (scl_line) begin
        hi_cnt <= hi_cnt + 1;
      end else if (scl_prev) begin
        last_hi <= hi_cnt;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic pulse_start();
    start_set = 1'b1; @(negedge clk); start_set = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    data_in = b; data_wr = 1'b1; @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_done(input int old);
    while (bytes_done == old) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int old;
    ack_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 status", {busy, irq, nak, start_pend, stop_pend, tx_pend}, 0);

    // R11: transmit request on idle bus stays pending, no clocks
    write_byte(8'h3C);
    repeat (40) @(negedge clk);
    chk("R11 tx_pend held", tx_pend, 1);
    chk("R11 no scl rises", rises + bytes_done, 0);
    chk("R11 busy", busy, 0);

    // R2: START
    pulse_start();
    chk("R2 start_pend set", start_pend, 1);
    while (!busy) @(negedge clk);
    chk("R2 start_pend cleared", start_pend, 0);
    repeat (2) @(negedge clk);
    chk("R2 start seen", starts, 1);

    // R4: pending byte moves to shifter
    old = bytes_done;
    wait_irq();
    chk("R4 tx_pend cleared with irq", tx_pend, 0);
    @(negedge clk);
    chk("R4 irq single cycle", irq, 0);
    wait_done(old);
    chk("R5 byte 3C", log_q[old], 8'h3C);
    chk("R6 clocks", per_byte, 9);
    chk("R7 nak when released", nak, 1);
    chk("R8 high phase", last_hi, HALF + 1);

    // table of bytes with both ack polarities
    for (int i = 0; i < NVEC; i++) begin
      ack_en = VEC[i][8];
      old = bytes_done;
      write_byte(VEC[i][7:0]);
      wait_irq();
      chk("R4 irq clears tx_pend", tx_pend, 0);
      wait_done(old);
      chk("R5 msb-first byte", log_q[old], VEC[i][7:0]);
      chk("R6 nine clocks", per_byte, 9);
      chk("R7 ack capture", nak, !VEC[i][8]);
    end
    chk("R5 no spurious start/stop", {starts[15:0], stops[15:0]}, 32'h0001_0000);

    // R3: back-to-back queuing
    ack_en = 1'b1;
    old = bytes_done;
    write_byte(8'h12);
    wait_irq();
    @(negedge clk);
    write_byte(8'h34);
    repeat (3) @(negedge clk);
    chk("R3 second byte waits", tx_pend, 1);
    chk("R3 first still in flight", bytes_done, old);
    wait_done(old);
    wait_done(old + 1);
    chk("R3 order first", log_q[old], 8'h12);
    chk("R3 order second", log_q[old + 1], 8'h34);
    chk("R8 high phase", last_hi, HALF + 1);

    // R10: repeated START
    old = starts;
    pulse_start();
    while (starts == old) @(negedge clk);
    chk("R10 busy kept", busy, 1);
    chk("R10 no stop", stops, 0);
    old = bytes_done;
    ack_en = 1'b0;
    write_byte(8'hC3);
    wait_done(old);
    chk("R10 byte after restart", log_q[old], 8'hC3);
    chk("R7 nak after restart", nak, 1);

    // R9: STOP
    stop_set = 1'b1; @(negedge clk); stop_set = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 stop seen", stops, 1);
    chk("R9 stop_pend cleared", stop_pend, 0);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    repeat (20) @(negedge clk);
    chk("R11 no clocks after stop", rises, 1);

    summary();
    $finish;
  end

endmodule